// File: doc/BRIEF.md
# Pulse-width capture channel

This block is a capture-mode timer channel that times each level of a single digital input. It counts cycles of its own clock, with no prescaling, while the input stays at one level. When the input changes level, the count for the phase that just ended goes into one of two period registers: the high-period register for a high phase, the low-period register for a low phase. The channel then records the polarity of that phase and raises an interrupt status flag. The input passes through a synchronizer before edge detection, so an asynchronous line can be connected directly.

Each edge also produces a one-cycle event on dedicated outputs. The event carries a polarity flag and the length of the phase in clock cycles, so a pulse/space decoder can take it without going through the registers. A polarity flag of 1 marks a space (the high phase has ended). A flag of 0 marks a pulse (the low phase has ended). To get a duration in time, multiply the count by the clock period. Software uses a small word-addressed register interface: it sets the run and interrupt-enable bits, clears the status flag by writing a one to it, and reads both period registers.

Top module: `pwcap_channel`

## Requirements
- R1: After reset, every register reads zero (address 0 control, 1 status, 2 high period, 3 low period), `irq` is low and `evt_valid` is low.
- R2: While control bit 0 (run) is clear, input transitions produce no event, leave status bit 0 clear and leave both period registers unchanged. The counter is held at zero.
- R3: When the input falls, the number of clock cycles it was high is stored in the high-period register (address 2) and status bit 1 reads 1. The low-period register keeps its value.
- R4: When the input rises, the number of clock cycles it was low is stored in the low-period register (address 3) and status bit 1 reads 0. The high-period register keeps its value.
- R5: Each captured edge gives exactly one cycle of `evt_valid`, with `evt_space` equal to status bit 1 and `evt_count` equal to the captured length. It appears three clock edges after the input change: two synchronizer stages and one capture stage.
- R6: Every capture sets status bit 0. Writing 1 to status bit 0 clears it, and writing 0 leaves it set. A capture in the same cycle as a clearing write takes priority.
- R7: `irq` is high exactly when status bit 0 and control bit 1 (interrupt enable) are both set.
- R8: The phase counter saturates at all ones, so a phase longer than 2^CNT_W-1 cycles is captured as all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous input line to be timed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 2 | Write data (the only writable bits are 0 and 1) |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq | output | 1 | Level interrupt request |
| evt_valid | output | 1 | One-cycle strobe for a captured phase |
| evt_space | output | 1 | 1 when the captured phase was high, 0 when it was low |
| evt_count | output | CNT_W | Length of the captured phase in clock cycles |

## Verification
The assertions check on every cycle the relations between internal events and outputs. An edge strobe is followed by an event one cycle later. An event always finds the status flag set and the matching period register equal to the event count. A stopped channel emits nothing. A saturated counter stays at all ones, and a clearing write with no capture in the same cycle drops the status flag. Only the bench scenarios can show that the captured lengths equal the cycles the input was actually held at each level. The same holds for the three-edge latency measured from the pin, the masking of the interrupt by its enable bit, and the full saturation value after a very long phase.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

  // Word addresses of the channel registers
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
  localparam int unsigned REG_HIGH = 2;
  localparam int unsigned REG_LOW  = 3;

  // Control register bit positions
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_IRQE_BIT = 1;

  // Status register bit positions
  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_POL_BIT  = 1;

  // Polarity of the phase that just ended
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shreg[LAST];

endmodule

// File: rtl/pwcap_phase_timer.sv
module pwcap_phase_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lvl,
  output logic             edge_o,
  output logic             ended_high_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Saturating increment: all ones is sticky
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  logic             lvl_d;
  logic [CNT_W-1:0] cnt_q;

  // Previous level tracks the line even while stopped, so starting
  // the channel never sees a stale transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign edge_o       = run & (lvl ^ lvl_d);
  assign ended_high_o = lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (edge_o) cnt_q <= ONE;
    else             cnt_q <= sat_inc(cnt_q);
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/pwcap_regs.sv
module pwcap_regs
  import pwcap_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_stb,
  input  logic              cap_high,
  input  logic [CNT_W-1:0]  cap_len,
  output logic              run_o,
  output logic              irqe_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  high_o,
  output logic [CNT_W-1:0]  low_o,
  output logic              irq,
  output logic              evt_valid,
  output logic              evt_space,
  output logic [CNT_W-1:0]  evt_count
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(REG_HIGH);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(REG_LOW);
  localparam int unsigned PAD = CNT_W - 2;

  logic             run_q, irqe_q, flag_q;
  phase_e           pol_q;
  logic [CNT_W-1:0] high_q, low_q;
  logic             ev_v_q, ev_s_q;
  logic [CNT_W-1:0] ev_c_q;

  logic wr_ctrl, clr_flag;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign clr_flag = wr_en && (wr_addr == A_STAT) && wr_data[STAT_FLAG_BIT];

  // Control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      irqe_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wr_data[CTRL_RUN_BIT];
      irqe_q <= wr_data[CTRL_IRQE_BIT];
    end
  end

  // Status flag: a capture wins over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (cap_stb)  flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end

  // Period registers and polarity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q <= '0;
      low_q  <= '0;
      pol_q  <= PH_LOW;
    end else if (cap_stb) begin
      if (cap_high) begin
        high_q <= cap_len;
        pol_q  <= PH_HIGH;
      end else begin
        low_q  <= cap_len;
        pol_q  <= PH_LOW;
      end
    end
  end

  // Event stream to the downstream decoder
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_v_q <= 1'b0;
      ev_s_q <= 1'b0;
      ev_c_q <= '0;
    end else begin
      ev_v_q <= cap_stb;
      if (cap_stb) begin
        ev_s_q <= cap_high;
        ev_c_q <= cap_len;
      end
    end
  end

  // Read mux
  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = {{PAD{1'b0}}, irqe_q, run_q};
      A_STAT:  rd_data = {{PAD{1'b0}}, pol_q == PH_HIGH, flag_q};
      A_HIGH:  rd_data = high_q;
      A_LOW:   rd_data = low_q;
      default: rd_data = '0;
    endcase
  end

  assign run_o     = run_q;
  assign irqe_o    = irqe_q;
  assign flag_o    = flag_q;
  assign high_o    = high_q;
  assign low_o     = low_q;
  assign irq       = flag_q & irqe_q;
  assign evt_valid = ev_v_q;
  assign evt_space = ev_s_q;
  assign evt_count = ev_c_q;

endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              evt_valid,
  output logic              evt_space,
  output logic [CNT_W-1:0]  evt_count
);

  // Named internal events, visible to the bound checker
  logic             line_sync;
  logic             ctrl_en;
  logic             irq_en;
  logic             int_sts;
  logic             edge_stb;
  logic             ended_high;
  logic [CNT_W-1:0] phase_cnt;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;

  pwcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sig_in),
    .q     (line_sync)
  );

  pwcap_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (ctrl_en),
    .lvl          (line_sync),
    .edge_o       (edge_stb),
    .ended_high_o (ended_high),
    .count_o      (phase_cnt)
  );

  pwcap_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cap_stb   (edge_stb),
    .cap_high  (ended_high),
    .cap_len   (phase_cnt),
    .run_o     (ctrl_en),
    .irqe_o    (irq_en),
    .flag_o    (int_sts),
    .high_o    (hi_q),
    .low_o     (lo_q),
    .irq       (irq),
    .evt_valid (evt_valid),
    .evt_space (evt_space),
    .evt_count (evt_count)
  );

endmodule

// File: rtl/pwcap_channel_chk.sv
module pwcap_channel_chk
  import pwcap_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              int_sts,
  input logic              irq,
  input logic              edge_stb,
  input logic [CNT_W-1:0]  phase_cnt,
  input logic [CNT_W-1:0]  hi_q,
  input logic [CNT_W-1:0]  lo_q,
  input logic              evt_valid,
  input logic              evt_space,
  input logic [CNT_W-1:0]  evt_count,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        wr_data
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

  // R2
  stopped_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !evt_valid);

  // R3
  high_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_space) |-> (hi_q == evt_count));

  // R4
  low_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_space) |-> (lo_q == evt_count));

  // R5
  edge_to_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> evt_valid);

  // R6
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> int_sts);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT && wr_data[STAT_FLAG_BIT] && !edge_stb) |=> !int_sts);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_sts);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !edge_stb && (&phase_cnt)) |=> (&phase_cnt));

endmodule

bind pwcap_channel pwcap_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .int_sts   (int_sts),
  .irq       (irq),
  .edge_stb  (edge_stb),
  .phase_cnt (phase_cnt),
  .hi_q      (hi_q),
  .lo_q      (lo_q),
  .evt_valid (evt_valid),
  .evt_space (evt_space),
  .evt_count (evt_count),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/sim_pwcap_channel.sv
module sim_pwcap_channel;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int AW = 2;
  localparam int NPH = 11;
  // Phase lengths; even index = high level, odd index = low level
  localparam int unsigned PH_LEN [NPH] = '{7, 12, 9, 20, 6, 33, 15, 8, 40, 11, 6};

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_HIGH = 2'd2;
  localparam logic [AW-1:0] A_LOW  = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          irq, evt_valid, evt_space;
  logic [CW-1:0] evt_count;

  int checks = 0;
  int errors = 0;
  int ev_n = 0;
  logic ev_space_last = 1'b0;
  logic [CW-1:0] ev_cnt_last = '0;
  bit finished = 1'b0;

  pwcap_channel #(.CNT_W(CW), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .evt_valid(evt_valid), .evt_space(evt_space), .evt_count(evt_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Event monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      ev_n          <= ev_n + 1;
      ev_space_last <= evt_space;
      ev_cnt_last   <= evt_count;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [CW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [CW-1:0] v;
    int ev0;
    bit lvl, prev_lvl;

    // R1: reset state
    cyc(3);
    for (int a = 0; a < 4; a++) begin
      reg_read(AW'(a), v);
      chk("R1 reg", 32'(v), 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 evt_valid", 32'(evt_valid), 32'h0);
    rst_n = 1'b1;
    cyc(1);

    // R2: stopped channel ignores the line
    sig_in = 1'b1; cyc(10);
    sig_in = 1'b0; cyc(10);
    chk("R2 events", 32'(ev_n), 32'h0);
    reg_read(A_STAT, v); chk("R2 status", 32'(v), 32'h0);
    reg_read(A_HIGH, v); chk("R2 high", 32'(v), 32'h0);
    reg_read(A_LOW, v);  chk("R2 low", 32'(v), 32'h0);

    // Start with interrupts enabled
    reg_write(A_CTRL, 2'b11);
    cyc(2);
    ev0 = ev_n;

    // Vector walk: each phase is checked during the phase after it
    for (int i = 0; i < NPH; i++) begin
      lvl = (i % 2 == 0);
      sig_in = lvl;
      cyc(4);
      chk("R5 event count", 32'(ev_n), 32'(ev0 + i + 1));
      if (i > 0) begin
        prev_lvl = !lvl;
        chk("R5 evt_space", 32'(ev_space_last), 32'(prev_lvl));
        chk("R5 evt_count", 32'(ev_cnt_last), PH_LEN[i-1]);
        if (prev_lvl) begin
          reg_read(A_HIGH, v); chk("R3 high period", 32'(v), PH_LEN[i-1]);
          if (i >= 2) begin
            reg_read(A_LOW, v); chk("R3 low kept", 32'(v), PH_LEN[i-2]);
          end
        end else begin
          reg_read(A_LOW, v);  chk("R4 low period", 32'(v), PH_LEN[i-1]);
          reg_read(A_HIGH, v); chk("R4 high kept", 32'(v), PH_LEN[i-2]);
        end
        reg_read(A_STAT, v);
        chk("R3 R4 polarity", 32'(v[1]), 32'(prev_lvl));
        chk("R6 flag set", 32'(v[0]), 32'h1);
        chk("R7 irq high", 32'(irq), 32'h1);
      end
      reg_write(A_STAT, 2'b01);
      reg_read(A_STAT, v);
      chk("R6 flag cleared", 32'(v[0]), 32'h0);
      chk("R7 irq low", 32'(irq), 32'h0);
      cyc(int'(PH_LEN[i]) - 5);
    end

    // R6: writing 0 leaves the flag set
    sig_in = 1'b0; cyc(6);
    reg_write(A_STAT, 2'b00);
    reg_read(A_STAT, v);
    chk("R6 write zero keeps flag", 32'(v[0]), 32'h1);
    chk("R7 irq with enable", 32'(irq), 32'h1);

    // R7: interrupt enable masks the request
    reg_write(A_CTRL, 2'b01);
    chk("R7 irq masked", 32'(irq), 32'h0);
    reg_read(A_STAT, v);
    chk("R7 flag still set", 32'(v[0]), 32'h1);
    reg_write(A_STAT, 2'b01);

    // R8: saturation on a very long high phase
    sig_in = 1'b1; cyc(300);
    sig_in = 1'b0; cyc(4);
    reg_read(A_HIGH, v);
    chk("R8 saturated high", 32'(v), 32'hFF);
    chk("R8 saturated event", 32'(ev_cnt_last), 32'hFF);

    // R2: stopping again freezes everything
    reg_write(A_CTRL, 2'b00);
    ev0 = ev_n;
    sig_in = 1'b1; cyc(8);
    sig_in = 1'b0; cyc(8);
    chk("R2 no events when stopped", 32'(ev_n), 32'(ev0));
    reg_read(A_HIGH, v);
    chk("R2 high frozen", 32'(v), 32'hFF);

    // R5: latency from the pin to the event strobe
    reg_write(A_CTRL, 2'b11);
    cyc(5);
    sig_in = 1'b1;
    cyc(2);
    chk("R5 not before third edge", 32'(evt_valid), 32'h0);
    cyc(1);
    chk("R5 strobe on third edge", 32'(evt_valid), 32'h1);
    chk("R5 strobe polarity", 32'(evt_space), 32'h0);
    cyc(1);
    chk("R5 single cycle", 32'(evt_valid), 32'h0);

    summary();
  end

endmodule